// File: doc/BRIEF.md
# Access Wait-State and Timer Prescale Generator

This block sets the length of each bus cycle of a small audio coprocessor. For each access, the core presents an address, or flags an idle cycle. The block sorts the access into one of two speed classes. It then looks up how many base clocks the access occupies and keeps the core stalled for that long. At the start of the access it also sends a single increment strobe to all three timer prescalers. The strobe carries the number of prescaler ticks that the access is worth.

Three kinds of access take their timing from the internal speed field:

- idle cycles,
- accesses to the sixteen-byte I/O page at 0x00F0–0x00FF,
- accesses to the boot ROM overlay at 0xFFC0 and above, but only while the overlay is mapped in.

Every other access takes its timing from the external speed field. Both speed fields are 2-bit selects, and one select value drives both lookups. The core waits for `acc_ready` before it issues the next access. The timers add `tick_amount` to their prescalers whenever `tick_valid` is high.

Top module: `acc_waitgen`

## Requirements
- R1: An idle request (`req_idle`=1) uses the internal speed field, whatever its address.
- R2: A non-idle access whose address has bits [15:4] equal to 0x00F uses the internal speed field. Addresses 0x00EF and 0x0100 use the external field.
- R3: A non-idle access at an address of 0xFFC0 or above uses the internal field when `rom_map`=1 and the external field when `rom_map`=0. Address 0xFFBF always uses the external field.
- R4: The selected speed value 0, 1, 2 or 3 makes an access last 2, 4, 10 or 20 base clocks. These are counted from the accepting edge to the edge that can accept the next access.
- R5: The selected speed value 0, 1, 2 or 3 gives a timer increment of 2, 4, 8 or 16 on the 5-bit `tick_amount` output.
- R6: `tick_valid` is high for exactly one cycle, the cycle right after the accepting edge, once per accepted access.
- R7: `acc_ready` is low for cost−1 cycles after acceptance. It returns high in the same cycle that `acc_done` pulses for one cycle.
- R8: A `req_valid` presented while `acc_ready` is low is ignored. It causes no tick strobe and does not change the running access.
- R9: The address, the idle flag, `rom_map` and both speed fields are sampled only at the accepting edge. Changes to them during an access have no effect on that access.
- R10: After reset, `acc_ready`=1, `tick_valid`=0 and `acc_done`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Access request, taken when acc_ready is high |
| req_idle | input | 1 | Request is an idle cycle rather than a memory access |
| req_addr | input | 16 | Access address |
| rom_map | input | 1 | Boot ROM overlay is mapped at the top of memory |
| spd_int | input | 2 | Internal speed select |
| spd_ext | input | 2 | External speed select |
| acc_ready | output | 1 | High when a new access may be accepted (stall when low) |
| acc_done | output | 1 | One-cycle pulse marking the end of an access |
| tick_valid | output | 1 | One-cycle timer increment strobe |
| tick_amount | output | 5 | Prescaler ticks added by the three timers |

## Verification
Two events share a cycle whenever the core keeps requesting without a break. The completion pulse of one access and the acceptance of the next both fall in the cycle where `acc_ready` comes back. The bench provokes this by presenting each new request in the very cycle that ready returns. Accesses of every cost, from 2 to 20 clocks, run back to back. The scoreboard checks that each access's tick strobe still lands one cycle after its own acceptance. It also checks that the gap from that strobe to the matching done pulse is exactly cost−1. An access cut short or stretched by the overlap would break that gap.

// File: rtl/acc_waitgen_pkg.sv
// Package: shared widths and the two speed lookup functions.
// Assumes a 2-bit speed select; cost and increment fit in 5 bits.
package acc_waitgen_pkg;
    localparam int SPD_W  = 2;
    localparam int CNT_W  = 5;
    localparam int INC_W  = 5;

    typedef logic [SPD_W-1:0] spd_t;
    typedef logic [CNT_W-1:0] cnt_t;
    typedef logic [INC_W-1:0] inc_t;

    // Base clocks spent by one access for a given speed select.
    function automatic cnt_t cost_of(input spd_t s);
        case (s)
            2'd0:    cost_of = cnt_t'(2);
            2'd1:    cost_of = cnt_t'(4);
            2'd2:    cost_of = cnt_t'(10);
            default: cost_of = cnt_t'(20);
        endcase
    endfunction

    // Prescaler ticks per access: doubles with each speed step, starting at 2.
    function automatic inc_t inc_of(input spd_t s);
        inc_of = inc_t'(2) << s;
    endfunction
endpackage

// File: rtl/acc_region_classify.sv
// Region classifier: decides whether an access takes the internal speed.
// Assumes the I/O page is an aligned block that a mask and match pick out,
// and that the ROM overlay spans ROM_BASE up to the top of the address space.
module acc_region_classify #(
    parameter int              ADDR_W   = 16,
    parameter logic [ADDR_W-1:0] IO_MASK  = 16'hFFF0,
    parameter logic [ADDR_W-1:0] IO_MATCH = 16'h00F0,
    parameter logic [ADDR_W-1:0] ROM_BASE = 16'hFFC0
) (
    input  logic              idle,
    input  logic [ADDR_W-1:0] addr,
    input  logic              rom_map,
    output logic              use_int
);
    logic io_hit;
    logic rom_hit;

    // Match the I/O page and the mapped ROM overlay, then merge with idle.
    always_comb begin
        io_hit  = (addr & IO_MASK) == IO_MATCH;
        rom_hit = rom_map && (addr >= ROM_BASE);
        use_int = idle || io_hit || rom_hit;
    end
endmodule

// File: rtl/acc_speed_lookup.sv
// Speed lookup: picks the speed field and maps it to cost and timer increment.
// Assumes the tables in acc_waitgen_pkg; purely combinational.
module acc_speed_lookup
    import acc_waitgen_pkg::*;
(
    input  logic use_int,
    input  spd_t spd_int,
    input  spd_t spd_ext,
    output cnt_t cost,
    output inc_t inc
);
    spd_t sel;

    // Choose the field and read both tables with the one select.
    always_comb begin
        sel  = use_int ? spd_int : spd_ext;
        cost = cost_of(sel);
        inc  = inc_of(sel);
    end
endmodule

// File: rtl/acc_stall_counter.sv
// Stall counter: holds ready low for cost-1 cycles after a load and pulses
// done as ready returns. Assumes load is only raised while ready is high
// and that the load value is at least 2.
module acc_stall_counter
    import acc_waitgen_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  cnt_t load_cost,
    output logic ready,
    output logic done
);
    cnt_t cnt_q;
    logic done_q;

    // Count remaining busy cycles; a load starts at cost-1.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_cost - cnt_t'(1);
        else if (cnt_q != '0)
            cnt_q <= cnt_q - cnt_t'(1);
    end

    // Flag the cycle in which the count reaches zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            done_q <= 1'b0;
        else
            done_q <= (cnt_q == cnt_t'(1)) && !load;
    end

    assign ready = (cnt_q == '0);
    assign done  = done_q;

    // R4: a busy count steps down by one every clock.
    a_r4_count_steps: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q != '0) |=> (cnt_q == $past(cnt_q) - cnt_t'(1)));

    // R7: done only ever appears together with ready.
    a_r7_done_with_ready: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ready);

    // R7: the done pulse lasts a single cycle.
    a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
endmodule

// File: rtl/acc_waitgen.sv
// Top: accepts accesses, sizes their stall and strobes the timer increment.
// Assumes the core keeps req_valid meaningful only when acc_ready is high.
module acc_waitgen
    import acc_waitgen_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_idle,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              rom_map,
    input  logic [1:0]        spd_int,
    input  logic [1:0]        spd_ext,
    output logic              acc_ready,
    output logic              acc_done,
    output logic              tick_valid,
    output logic [4:0]        tick_amount
);
    logic use_int;
    cnt_t cost;
    inc_t inc;
    logic accept;
    logic tick_q;
    inc_t amt_q;

    acc_region_classify #(.ADDR_W(ADDR_W)) u_classify (
        .idle    (req_idle),
        .addr    (req_addr),
        .rom_map (rom_map),
        .use_int (use_int)
    );

    acc_speed_lookup u_lookup (
        .use_int (use_int),
        .spd_int (spd_int),
        .spd_ext (spd_ext),
        .cost    (cost),
        .inc     (inc)
    );

    assign accept = req_valid && acc_ready;

    acc_stall_counter u_stall (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (accept),
        .load_cost (cost),
        .ready     (acc_ready),
        .done      (acc_done)
    );

    // Register the increment strobe for the cycle after acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tick_q <= 1'b0;
            amt_q  <= '0;
        end else begin
            tick_q <= accept;
            if (accept)
                amt_q <= inc;
        end
    end

    assign tick_valid  = tick_q;
    assign tick_amount = amt_q;

    // R6: an accepted access strobes the timers on the next cycle.
    a_r6_tick_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && acc_ready) |=> tick_valid);

    // R8: a strobe always belongs to a running access.
    a_r8_tick_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        tick_valid |-> !acc_ready);

    // R5: every increment is a single power of two.
    a_r5_amount_pow2: assert property (@(posedge clk) disable iff (!rst_n)
        tick_valid |-> ($countones(tick_amount) == 1 && !tick_amount[0]));
endmodule

// File: tb/acc_waitgen_bench.sv
module acc_waitgen_bench;
    localparam time CLK_PERIOD = 10ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_idle = 1'b0;
    logic [15:0] req_addr = '0;
    logic        rom_map = 1'b0;
    logic [1:0]  spd_int = '0;
    logic [1:0]  spd_ext = '0;
    logic        acc_ready, acc_done, tick_valid;
    logic [4:0]  tick_amount;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int issued = 0;
    int seen = 0;
    bit finished = 1'b0;

    int    q_cost[$];
    int    q_inc[$];
    string q_tag[$];

    acc_waitgen u_acc_waitgen (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_idle(req_idle),
        .req_addr(req_addr), .rom_map(rom_map), .spd_int(spd_int), .spd_ext(spd_ext),
        .acc_ready(acc_ready), .acc_done(acc_done), .tick_valid(tick_valid),
        .tick_amount(tick_amount)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // Driver: wait for ready, push expectations, present one request, then scramble inputs.
    task automatic issue(input logic idl, input logic [15:0] a, input logic rom,
                         input logic [1:0] si, input logic [1:0] se, input string tag);
        logic internal;
        logic [1:0] s;
        int cost;
        internal = idl || (a[15:4] == 12'h00F) || (rom && a >= 16'hFFC0);
        s = internal ? si : se;
        case (s)
            2'd0: cost = 2;
            2'd1: cost = 4;
            2'd2: cost = 10;
            default: cost = 20;
        endcase
        while (!acc_ready) @(negedge clk);
        q_cost.push_back(cost);
        q_inc.push_back(2 << s);
        q_tag.push_back(tag);
        issued++;
        req_valid = 1'b1; req_idle = idl; req_addr = a; rom_map = rom;
        spd_int = si; spd_ext = se;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        // R9: mid-access changes must not alter the running access
        spd_int = ~si; spd_ext = ~se; req_addr = a ^ 16'h5A5A;
        rom_map = ~rom; req_idle = ~idl;
    endtask

    // Monitor: pop an expectation on each strobe, judge the done spacing.
    int tick_cyc = 0;
    int cur_cost = 0;
    string cur_tag = "";
    bit active = 1'b0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (acc_done) begin
                check(active, "R7 done without access", 0, 1);
                if (active) begin
                    check(cyc - tick_cyc == cur_cost - 1, {"R4/R7 ", cur_tag},
                          cyc - tick_cyc + 1, cur_cost);
                    check(acc_ready == 1'b1, "R7 ready with done", acc_ready, 1);
                end
                active = 1'b0;
            end
            if (tick_valid) begin
                seen++;
                if (q_inc.size() == 0) begin
                    check(1'b0, "R8/R6 unexpected tick", seen, issued);
                end else begin
                    cur_cost = q_cost.pop_front();
                    cur_tag  = q_tag.pop_front();
                    check(tick_amount == q_inc[0], {"R5 ", cur_tag}, tick_amount, q_inc[0]);
                    void'(q_inc.pop_front());
                    check(acc_ready == 1'b0, "R7 stall during access", acc_ready, 0);
                    tick_cyc = cyc;
                    active = 1'b1;
                end
            end
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(acc_ready == 1'b1, "R10 ready", acc_ready, 1);
        check(tick_valid == 1'b0, "R10 tick", tick_valid, 0);
        check(acc_done == 1'b0, "R10 done", acc_done, 0);

        // R1: idle takes internal speed across all selects
        for (int s = 0; s < 4; s++) begin
            issue(1'b1, 16'h1234, 1'b0, 2'(s), 2'(3 - s), "R1 idle");
        end
        // R2: I/O page edges
        issue(1'b0, 16'h00F0, 1'b0, 2'd2, 2'd0, "R2 io low");
        issue(1'b0, 16'h00FF, 1'b0, 2'd1, 2'd3, "R2 io high");
        issue(1'b0, 16'h00EF, 1'b0, 2'd2, 2'd1, "R2 below io");
        issue(1'b0, 16'h0100, 1'b0, 2'd3, 2'd0, "R2 above io");
        // R3: ROM overlay on and off
        issue(1'b0, 16'hFFC0, 1'b1, 2'd0, 2'd3, "R3 rom base mapped");
        issue(1'b0, 16'hFFFF, 1'b1, 2'd1, 2'd2, "R3 rom top mapped");
        issue(1'b0, 16'hFFC0, 1'b0, 2'd0, 2'd2, "R3 rom unmapped");
        issue(1'b0, 16'hFFBF, 1'b1, 2'd0, 2'd1, "R3 below rom");
        // R4/R5: every external select, back to back
        for (int s = 0; s < 4; s++) begin
            issue(1'b0, 16'h4000, 1'b0, 2'd0, 2'(s), "R4 R5 ext sweep");
        end
        // R8: requests during a long access are ignored
        issue(1'b0, 16'h8000, 1'b0, 2'd0, 2'd3, "R8 long access");
        repeat (3) begin
            req_valid = 1'b1; req_addr = 16'h0000; spd_ext = 2'd0;
            @(negedge clk);
            req_valid = 1'b0;
            @(negedge clk);
        end
        while (!acc_ready) @(negedge clk);
        repeat (4) @(negedge clk);
        check(seen == issued, "R8 tick count", seen, issued);
        check(q_inc.size() == 0, "R6 pending strobes", q_inc.size(), 0);
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule